// File: doc/BRIEF.md
# External Interrupt Entry Sequencer

This block sits beside the completion stage of a simple in-order core and turns a level-sensitive external interrupt line into a precise exception entry. A request counts only while the enable bit of the machine state register is set. Once counted, the block lets the oldest in-flight instruction finish or fault, then holds back every later completion. It waits for the queue of completed stores to empty, and only then commits the entry.

Any other exception request seen on the way wins. The sequence is abandoned and starts again from idle while the line is still held. Nothing about the request is remembered, so the source must keep the line asserted until entry happens. On entry the block writes both save/restore registers and the machine state register at one clock edge. The cycle after, it issues a one-cycle fetch redirect to the interrupt vector. The block also owns the machine state register, which the core can load through a write port.

All bit positions below use LSB-0 numbering of the 32-bit machine state register (MSR): LE=0, RI=1, DR=4, IR=5, IP=6, FE1=8, BE=9, SE=10, FE0=11, ME=12, FP=13, PR=14, EE=15, ILE=16, TGPR=17, POW=18.

Top module: `ext_irq_entry`

## Requirements
- R1: After a cycle with `rst_n` low, `msr` equals `MSR_RESET`, `srr0` and `srr1` are zero, and `block_complete` and `redirect_valid` are low.
- R2: While MSR bit 15 (EE) is 0, a held `irq_req` starts no sequence. `block_complete` stays low and no register changes.
- R3: A request seen in idle with EE=1 and no `other_exc` starts a halt. `block_complete` stays low until a cycle with `insn_done` high or `insn_pending` low, and rises on the next cycle.
- R4: While `block_complete` is high and `sq_empty` is low, with the request still qualified, `block_complete` stays high and no entry happens. Entry takes place at the edge where `sq_empty` is seen high.
- R5: `other_exc` high in any cycle abandons the sequence. `block_complete` is low on the next cycle, no entry happens, and a still-held request restarts from idle.
- R6: Dropping `irq_req`, or clearing EE, before entry aborts the sequence, and no register is written by it.
- R7: At entry, `srr0` is loaded with `next_pc` as presented in the entry cycle.
- R8: At entry, `srr1[31:16]` is cleared and `srr1[15:0]` is copied from the old `msr[15:0]`.
- R9: At entry, the new MSR keeps ILE (16), IP (6) and ME (12), sets LE (0) to the old ILE, and clears every other bit.
- R10: The cycle after entry, `redirect_valid` is high for exactly one cycle. `redirect_addr` is `VEC_OFFSET` when IP is 0, and `HIGH_BASE | VEC_OFFSET` when IP is 1.
- R11: `msr_wr_en` loads `msr_wr_data` into the MSR at the next edge unless entry happens at that edge; entry has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 1 | Level-sensitive external interrupt request |
| other_exc | input | 1 | Any higher-priority exception request from the core |
| insn_pending | input | 1 | An instruction is in flight toward completion |
| insn_done | input | 1 | The oldest in-flight instruction completed or faulted this cycle |
| sq_empty | input | 1 | The completed-store queue is empty |
| next_pc | input | ADDR_W | Address of the instruction that would execute next |
| msr_wr_en | input | 1 | Core write strobe for the MSR |
| msr_wr_data | input | 32 | Value for a core MSR write |
| block_complete | output | 1 | Holds back completion of all later instructions |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_addr | output | ADDR_W | Interrupt vector address |
| msr | output | 32 | Machine state register |
| srr0 | output | ADDR_W | Saved return address |
| srr1 | output | 32 | Saved machine state image |

## Verification
The bench keeps `VEC_OFFSET` and `HIGH_BASE` at their defaults, so both vector bases appear as 0x00000500 and 0xFFF00500. It overrides `MSR_RESET` to 0x00001040, which sets IP and ME and clears EE. With that override, an interrupt held straight out of reset is the ignored case, and reset already shows the IP base choice. A model compares every output each cycle through slow store drains, competing exceptions in idle and in the drain phase, and withdrawals of the request or of EE.

// File: rtl/ext_irq_pkg.sv
// Package: shared types and MSR bit positions (LSB-0) for the interrupt entry block.
// Assumes a 32-bit machine state register.
package ext_irq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_HALT  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

    localparam int MSR_W    = 32;
    localparam int HALF_W   = MSR_W / 2;
    localparam int B_LE     = 0;
    localparam int B_RI     = 1;
    localparam int B_DR     = 4;
    localparam int B_IR     = 5;
    localparam int B_IP     = 6;
    localparam int B_FE1    = 8;
    localparam int B_BE     = 9;
    localparam int B_SE     = 10;
    localparam int B_FE0    = 11;
    localparam int B_ME     = 12;
    localparam int B_FP     = 13;
    localparam int B_PR     = 14;
    localparam int B_EE     = 15;
    localparam int B_ILE    = 16;
    localparam int B_TGPR   = 17;
    localparam int B_POW    = 18;
endpackage

// File: rtl/irq_halt_ctrl.sv
// Module: recognises the qualified interrupt and walks the halt sequence:
// wait for the oldest instruction, block later completions, wait for the
// store queue, then fire a one-cycle entry strobe.
// Assumes at most one completion per cycle; any other exception aborts.
module irq_halt_ctrl
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic irq_enable,
    input  logic other_exc,
    input  logic insn_pending,
    input  logic insn_done,
    input  logic sq_empty,
    output logic block_complete,
    output logic enter
);
    phase_e ph_q;
    phase_e ph_d;
    logic   qual;
    logic   oldest_clear;

    // Request is live only with enable set and nothing of higher priority.
    assign qual         = irq_req & irq_enable & ~other_exc;
    assign oldest_clear = insn_done | ~insn_pending;

    // Next-phase and entry decision.
    always_comb begin
        ph_d  = ph_q;
        enter = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (qual) ph_d = PH_HALT;
            end
            PH_HALT: begin
                if (!qual)             ph_d = PH_IDLE;
                else if (oldest_clear) ph_d = PH_DRAIN;
            end
            PH_DRAIN: begin
                if (!qual) begin
                    ph_d = PH_IDLE;
                end else if (sq_empty) begin
                    enter = 1'b1;
                    ph_d  = PH_IDLE;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    assign block_complete = (ph_q == PH_DRAIN);

    // R2 R6
    no_live_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req || !irq_enable) |=> (!block_complete && !enter));

    // R5
    other_exc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        other_exc |=> !block_complete);

    // R3
    block_after_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(block_complete) |-> $past(insn_done || !insn_pending));

    // R4
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_complete && !sq_empty && irq_req && irq_enable && !other_exc)
        |=> block_complete);
endmodule

// File: rtl/irq_entry_image.sv
// Module: computes the register images written at entry: the new MSR,
// the SRR1 image and the vector address. Pure combinational.
// Assumes the IP bit of the current MSR selects the vector base.
module irq_entry_image
    import ext_irq_pkg::*;
#(
    parameter int               ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] VEC_OFFSET = 'h500,
    parameter logic [ADDR_W-1:0] HIGH_BASE  = 'hFFF0_0000
) (
    input  logic [MSR_W-1:0]  msr_cur,
    output logic [MSR_W-1:0]  msr_entry,
    output logic [MSR_W-1:0]  srr1_entry,
    output logic [ADDR_W-1:0] vector
);
    localparam logic [MSR_W-1:0] KEEP_MASK =
        (MSR_W'(1) << B_ILE) | (MSR_W'(1) << B_IP) | (MSR_W'(1) << B_ME);

    // New MSR: keep ILE, IP, ME; LE follows ILE; everything else cleared.
    always_comb begin
        msr_entry       = msr_cur & KEEP_MASK;
        msr_entry[B_LE] = msr_cur[B_ILE];
    end

    // SRR1: upper half cleared, lower half copied bit by bit.
    for (genvar g = 0; g < MSR_W; g++) begin : g_srr1
        if (g < HALF_W) begin : g_copy
            assign srr1_entry[g] = msr_cur[g];
        end else begin : g_zero
            assign srr1_entry[g] = 1'b0;
        end
    end

    // Vector base chosen by IP.
    assign vector = (msr_cur[B_IP] ? HIGH_BASE : '0) | VEC_OFFSET;
endmodule

// File: rtl/irq_arch_regs.sv
// Module: holds MSR, SRR0, SRR1 and the registered fetch redirect.
// Entry has priority over a core MSR write in the same cycle.
module irq_arch_regs
    import ext_irq_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter logic [MSR_W-1:0] MSR_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              msr_wr_en,
    input  logic [MSR_W-1:0]  msr_wr_data,
    input  logic [MSR_W-1:0]  msr_entry,
    input  logic [MSR_W-1:0]  srr1_entry,
    input  logic [ADDR_W-1:0] vector,
    output logic [MSR_W-1:0]  msr,
    output logic [ADDR_W-1:0] srr0,
    output logic [MSR_W-1:0]  srr1,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr
);
    // MSR: reset value, entry image, or core write.
    always_ff @(posedge clk) begin
        if (!rst_n)         msr <= MSR_RESET;
        else if (enter)     msr <= msr_entry;
        else if (msr_wr_en) msr <= msr_wr_data;
    end

    // Save/restore registers load only at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srr0 <= '0;
            srr1 <= '0;
        end else if (enter) begin
            srr0 <= next_pc;
            srr1 <= srr1_entry;
        end
    end

    // One-cycle redirect strobe with its target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_addr  <= '0;
        end else begin
            redirect_valid <= enter;
            if (enter) redirect_addr <= vector;
        end
    end

    // R7
    srr0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (srr0 == $past(next_pc)));

    // R8
    srr1_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (srr1[MSR_W-1:HALF_W] == '0 && srr1[HALF_W-1:0] == $past(msr[HALF_W-1:0])));

    // R9
    msr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (!msr[B_EE] && !msr[B_PR] && msr[B_LE] == $past(msr[B_ILE])
                   && msr[B_ME] == $past(msr[B_ME])));

    // R10
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    // R11
    msr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_wr_en && !enter) |=> (msr == $past(msr_wr_data)));
endmodule

// File: rtl/ext_irq_entry.sv
// Module: top of the external interrupt entry block. Wires the halt
// sequencer, the entry image logic and the architectural registers.
// Assumes the core honours block_complete in the same cycle it is seen.
module ext_irq_entry
    import ext_irq_pkg::*;
#(
    parameter int               ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] VEC_OFFSET = 'h500,
    parameter logic [ADDR_W-1:0] HIGH_BASE  = 'hFFF0_0000,
    parameter logic [31:0]       MSR_RESET  = 32'h0000_0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              other_exc,
    input  logic              insn_pending,
    input  logic              insn_done,
    input  logic              sq_empty,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              msr_wr_en,
    input  logic [31:0]       msr_wr_data,
    output logic              block_complete,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic [31:0]       msr,
    output logic [ADDR_W-1:0] srr0,
    output logic [31:0]       srr1
);
    logic              enter;
    logic [MSR_W-1:0]  msr_entry;
    logic [MSR_W-1:0]  srr1_entry;
    logic [ADDR_W-1:0] vector;

    irq_halt_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_req        (irq_req),
        .irq_enable     (msr[B_EE]),
        .other_exc      (other_exc),
        .insn_pending   (insn_pending),
        .insn_done      (insn_done),
        .sq_empty       (sq_empty),
        .block_complete (block_complete),
        .enter          (enter)
    );

    irq_entry_image #(
        .ADDR_W     (ADDR_W),
        .VEC_OFFSET (VEC_OFFSET),
        .HIGH_BASE  (HIGH_BASE)
    ) u_image (
        .msr_cur    (msr),
        .msr_entry  (msr_entry),
        .srr1_entry (srr1_entry),
        .vector     (vector)
    );

    irq_arch_regs #(
        .ADDR_W    (ADDR_W),
        .MSR_RESET (MSR_RESET)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .enter          (enter),
        .next_pc        (next_pc),
        .msr_wr_en      (msr_wr_en),
        .msr_wr_data    (msr_wr_data),
        .msr_entry      (msr_entry),
        .srr1_entry     (srr1_entry),
        .vector         (vector),
        .msr            (msr),
        .srr0           (srr0),
        .srr1           (srr1),
        .redirect_valid (redirect_valid),
        .redirect_addr  (redirect_addr)
    );

    // R10
    redirect_follows_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (redirect_valid && redirect_addr[11:0] == VEC_OFFSET[11:0]));
endmodule

// File: tb/ext_irq_entry_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module ext_irq_entry_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RST_MSR    = 32'h0000_1040;
    localparam logic [31:0] VEC        = 32'h0000_0500;
    localparam logic [31:0] HIBASE     = 32'hFFF0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0, other_exc = 1'b0, insn_pending = 1'b0;
    logic        insn_done = 1'b0, sq_empty = 1'b1, msr_wr_en = 1'b0;
    logic [31:0] next_pc = '0, msr_wr_data = '0;
    logic        block_complete, redirect_valid;
    logic [31:0] redirect_addr, msr, srr0, srr1;

    int checks = 0;
    int errors = 0;
    int entries = 0;
    logic [31:0] last_vec = '0;
    bit started = 0;

    ext_irq_entry #(.MSR_RESET(RST_MSR)) u_ext_irq_entry (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .other_exc(other_exc),
        .insn_pending(insn_pending), .insn_done(insn_done), .sq_empty(sq_empty),
        .next_pc(next_pc), .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
        .block_complete(block_complete), .redirect_valid(redirect_valid),
        .redirect_addr(redirect_addr), .msr(msr), .srr0(srr0), .srr1(srr1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state.
    int          m_phase = 0;   // 0 idle, 1 waiting for oldest, 2 draining
    logic [31:0] m_msr = '0, m_srr0 = '0, m_srr1 = '0, m_ra = '0;
    bit          m_rv = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit live;
        bit ent;
        logic [31:0] nm;
        started = 1;
        ent = 0;
        if (!rst_n) begin
            m_phase = 0; m_msr = RST_MSR; m_srr0 = 0; m_srr1 = 0; m_rv = 0; m_ra = 0;
        end else begin
            live = irq_req && m_msr[15] && !other_exc;
            if (m_phase == 0) begin
                if (live) m_phase = 1;
            end else if (m_phase == 1) begin
                if (!live) m_phase = 0;
                else if (insn_done || !insn_pending) m_phase = 2;
            end else begin
                if (!live) m_phase = 0;
                else if (sq_empty) begin ent = 1; m_phase = 0; end
            end
            m_rv = ent;
            if (ent) begin
                m_ra   = (m_msr[6] ? HIBASE : 32'h0) | VEC;
                m_srr0 = next_pc;
                m_srr1 = {16'h0, m_msr[15:0]};
                nm = 32'h0;
                nm[16] = m_msr[16]; nm[6] = m_msr[6]; nm[12] = m_msr[12]; nm[0] = m_msr[16];
                m_msr = nm;
            end else if (msr_wr_en) begin
                m_msr = msr_wr_data;
            end
        end
    end

    // Per-cycle comparison and entry monitor.
    always @(negedge clk) begin
        if (started) begin
            check(msr == m_msr, "R9/R11 msr", msr, m_msr);
            check(srr0 == m_srr0, "R7 srr0", srr0, m_srr0);
            check(srr1 == m_srr1, "R8 srr1", srr1, m_srr1);
            check(block_complete == (m_phase == 2), "R3/R4/R5 block_complete",
                  32'(block_complete), 32'(m_phase == 2));
            check(redirect_valid == m_rv, "R10 redirect_valid", 32'(redirect_valid), 32'(m_rv));
            if (m_rv) check(redirect_addr == m_ra, "R10 redirect_addr", redirect_addr, m_ra);
            if (redirect_valid && rst_n) begin
                entries++;
                last_vec = redirect_addr;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic write_msr(input logic [31:0] v);
        msr_wr_en = 1; msr_wr_data = v;
        cyc(1);
        msr_wr_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int e0;
        cyc(3);
        rst_n = 1;
        // R1 reset state
        check(msr == RST_MSR, "R1 msr reset", msr, RST_MSR);
        check(srr0 == 0 && srr1 == 0, "R1 srr reset", srr0 | srr1, 0);
        check(!block_complete && !redirect_valid, "R1 outputs low",
              32'({block_complete, redirect_valid}), 0);

        // R2: EE clear, request held
        irq_req = 1; insn_pending = 1; sq_empty = 0;
        cyc(12);
        check(entries == 0, "R2 no entry with EE=0", entries, 0);
        check(!block_complete, "R2 no halt", 32'(block_complete), 0);
        check(msr == RST_MSR, "R2 msr untouched", msr, RST_MSR);
        irq_req = 0;
        cyc(1);

        // R11: core write
        write_msr(32'h0005_F472);
        check(msr == 32'h0005_F472, "R11 msr write", msr, 32'h0005_F472);

        // R3/R4: halt then slow drain
        next_pc = 32'h0000_2000;
        irq_req = 1;
        cyc(4);
        check(!block_complete, "R3 waits for oldest", 32'(block_complete), 0);
        insn_done = 1;
        cyc(1);
        insn_done = 0;
        cyc(1);
        check(block_complete, "R3 blocks after oldest", 32'(block_complete), 1);
        cyc(6);
        check(block_complete && entries == 0, "R4 holds during drain", entries, 0);
        sq_empty = 1;
        cyc(2);
        check(entries == 1, "R4 entry after drain", entries, 1);
        check(srr0 == 32'h2000, "R7 srr0", srr0, 32'h2000);
        check(srr1 == 32'h0000_F472, "R8 srr1", srr1, 32'h0000_F472);
        check(msr == 32'h0001_1041, "R9 msr image", msr, 32'h0001_1041);
        check(last_vec == 32'hFFF0_0500, "R10 high vector", last_vec, 32'hFFF0_0500);
        irq_req = 0;
        cyc(2);

        // R5: competing exception in idle, then released
        write_msr(32'h0000_9000);
        insn_pending = 0; next_pc = 32'h0000_3300;
        irq_req = 1; other_exc = 1;
        cyc(5);
        check(entries == 1 && !block_complete, "R5 other wins in idle", entries, 1);
        other_exc = 0;
        cyc(5);
        check(entries == 2, "R5 entry after other clears", entries, 2);
        check(last_vec == 32'h0000_0500, "R10 low vector", last_vec, 32'h0000_0500);
        check(srr1 == 32'h0000_9000 && msr == 32'h0000_1000, "R8/R9 second entry", msr, 32'h1000);
        irq_req = 0;
        cyc(2);

        // R5: competing exception during drain
        write_msr(32'h0000_8040);
        sq_empty = 0; irq_req = 1;
        cyc(4);
        check(block_complete, "R5 draining before other", 32'(block_complete), 1);
        other_exc = 1;
        cyc(1);
        other_exc = 0;
        check(!block_complete, "R5 drain abandoned", 32'(block_complete), 0);
        cyc(4);
        check(block_complete && entries == 2, "R5 restart while held", entries, 2);

        // R6: request dropped while draining
        irq_req = 0;
        cyc(1);
        sq_empty = 1;
        cyc(4);
        check(entries == 2 && srr0 == 32'h3300, "R6 dropped request", entries, 2);

        // R6: EE cleared during the halt
        sq_empty = 0; insn_pending = 1; irq_req = 1;
        cyc(2);
        write_msr(32'h0000_0040);
        sq_empty = 1; insn_done = 1;
        cyc(5);
        insn_done = 0;
        e0 = entries;
        check(e0 == 2 && msr == 32'h40, "R6 EE cleared aborts", msr, 32'h40);
        irq_req = 0;
        cyc(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule